// File: doc/BRIEF.md
# Control Channel Transaction Watchdog

This block guards a bidirectional control channel against transactions that never finish. A start pulse opens a watch window. A done pulse closes it quietly. If the programmed time runs out first, the block sends a single-cycle abort so that the channel logic can drop the hung transaction. It also raises a sticky timeout flag that stays up until it is cleared on purpose. The watchdog never resets anything beyond the transaction it aborts.

Time is measured in coarse ticks made by a prescaler. Each tick is `TICK_CYCLES` clock cycles, which is 2 ms in a real system. The block holds its own configuration register:

- The upper `TMO_W` bits give the timeout, counted in ticks.
- The lowest bit turns watchdog operation off.
- A zero timeout is not a valid setting. The block treats it as the largest count, so it can never expire at once.
- Changing the timeout, or turning the watchdog back on, while a transaction is open restarts the count.

Top module: `cc_txn_watchdog`

## Requirements
- R1: After a synchronous reset, `cfg_q` reads 0xFE (timeout 127, watchdog on), and both `abort_pulse` and `timeout_flag` read 0.
- R2: A write strobe loads `cfg_wdata` into the register, and `cfg_q` shows it from the next cycle. Bits 7:1 are the timeout in ticks and bit 0 is the disable bit (1 = off).
- R3: With a timeout field of L (1..127) and the watchdog on, `abort_pulse` rises L*TICK_CYCLES clock edges after the edge that samples `txn_start`.
- R4: A timeout field of 0 behaves exactly like 127.
- R5: A `txn_done` sampled before or on the expiry edge closes the transaction. No abort is produced and the flag stays unchanged.
- R6: Expiry produces exactly one abort cycle and sets `timeout_flag`. The flag stays set on later idle cycles.
- R7: A `flag_clr` sampled at an edge clears `timeout_flag`. If that same edge also sets the flag, the set wins.
- R8: While bit 0 is 1, an open transaction never produces an abort, however long it lasts.
- R9: Writing bit 0 from 1 to 0 while a transaction is open restarts the count. The abort then comes L*TICK_CYCLES edges after the write edge.
- R10: Writing a different timeout field while a transaction is open restarts the count with the new value, measured from the write edge.
- R11: A `txn_start` while a transaction is already open restarts the count. If `txn_start` and `txn_done` arrive together, the start wins.
- R12: No abort is produced while no transaction is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Pulse: a control channel transaction begins |
| txn_done | input | 1 | Pulse: the open transaction completed |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration data: timeout in bits 7:1, disable in bit 0 |
| cfg_q | output | 8 | Current configuration register value |
| flag_clr | input | 1 | Write-one-to-clear for the timeout flag |
| abort_pulse | output | 1 | One-cycle request to terminate the open transaction |
| timeout_flag | output | 1 | Sticky record that a timeout occurred |

## Verification
The bench sweeps every timeout value, including the zero code, and measures the exact edge count to the abort.

It also probes the corner cases where a wrong design would show itself:
- Completion landing on the very expiry edge catches a design whose abort wins that race.
- A clear landing on the expiry edge catches a flag that loses the set.
- Writes while a transaction is open catch a design that keeps the old count, or never wakes from the disabled state.
- A start paired with a done catches a design that lets the done close the new transaction.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_HOLD = 2'd2
  } wd_state_e;

  // Timeout field width to full register width (field + disable bit).
  function automatic int cfg_width(input int tmo_w);
    return tmo_w + 1;
  endfunction

  // Width needed to hold a prescaler phase 0..n-1 (at least one bit).
  function automatic int phase_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
  parameter int TMO_W = 7,
  localparam int CFG_W = wdt_pkg::cfg_width(TMO_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q,
  output logic [TMO_W-1:0] limit,
  output logic             eff_dis,
  output logic             restart
);

  localparam logic [TMO_W-1:0] TMO_MAX = {TMO_W{1'b1}};
  localparam logic [CFG_W-1:0] CFG_RST = {TMO_MAX, 1'b0};

  logic [TMO_W-1:0] cur_tmo;
  logic [TMO_W-1:0] new_tmo;
  logic             cur_dis;
  logic             new_dis;

  assign cur_tmo = q[CFG_W-1:1];
  assign cur_dis = q[0];
  assign new_tmo = wdata[CFG_W-1:1];
  assign new_dis = wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= CFG_RST;
    end else if (we) begin
      q <= wdata;
    end
  end

  // A zero field is illegal: it maps onto the longest count.
  assign limit = (cur_tmo == '0) ? TMO_MAX : cur_tmo;

  // Disable as seen at this edge, so a write acts at once.
  assign eff_dis = we ? new_dis : cur_dis;

  // Restart on a timeout change or on re-enable.
  assign restart = we & ((new_tmo != cur_tmo) | (cur_dis & ~new_dis));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_CYCLES = 100000,
  localparam int PH_W = wdt_pkg::phase_width(TICK_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);

  generate
    if (TICK_CYCLES <= 1) begin : g_direct
      // Every cycle is a tick; a restart edge carries none.
      assign tick = run & ~clear;
    end else begin : g_divided
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_CYCLES - 1);
      logic [PH_W-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          phase <= '0;
        end else if (run) begin
          phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
      end

      assign tick = run & ~clear & (phase == PH_LAST);
    end
  endgenerate

endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr #(
  parameter int TMO_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  logic [TMO_W-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ticks <= '0;
    end else if (tick) begin
      ticks <= ticks + 1'b1;
    end
  end

  // Limit is never zero, so limit-1 cannot wrap.
  assign expire = tick & (ticks == limit - 1'b1);

endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/cc_txn_watchdog.sv
module cc_txn_watchdog #(
  parameter int TMO_W       = 7,
  parameter int TICK_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic             txn_done,
  input  logic             cfg_we,
  input  logic [TMO_W:0]   cfg_wdata,
  output logic [TMO_W:0]   cfg_q,
  input  logic             flag_clr,
  output logic             abort_pulse,
  output logic             timeout_flag
);

  import wdt_pkg::*;

  wd_state_e        state;
  wd_state_e        state_nxt;
  logic [TMO_W-1:0] limit;
  logic             eff_dis;
  logic             cfg_restart;
  logic             ctr_clear;
  logic             run;
  logic             tick;
  logic             expire;
  logic             fire;

  wdt_cfg_reg #(.TMO_W(TMO_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .q       (cfg_q),
    .limit   (limit),
    .eff_dis (eff_dis),
    .restart (cfg_restart)
  );

  assign run       = (state == WD_RUN);
  assign ctr_clear = txn_start | cfg_restart;

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .clear (ctr_clear),
    .tick  (tick)
  );

  wdt_timeout_ctr #(.TMO_W(TMO_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .clear  (ctr_clear),
    .tick   (tick),
    .limit  (limit),
    .expire (expire)
  );

  // Priority: start, done, restart by config, expiry, disable.
  always_comb begin
    state_nxt = state;
    fire      = 1'b0;
    unique case (state)
      WD_IDLE: begin
        if (txn_start) state_nxt = eff_dis ? WD_HOLD : WD_RUN;
      end
      WD_RUN: begin
        if (txn_start) begin
          state_nxt = eff_dis ? WD_HOLD : WD_RUN;
        end else if (txn_done) begin
          state_nxt = WD_IDLE;
        end else if (cfg_restart) begin
          state_nxt = eff_dis ? WD_HOLD : WD_RUN;
        end else if (expire) begin
          state_nxt = WD_IDLE;
          fire      = 1'b1;
        end else if (eff_dis) begin
          state_nxt = WD_HOLD;
        end
      end
      WD_HOLD: begin
        if (txn_start) begin
          state_nxt = eff_dis ? WD_HOLD : WD_RUN;
        end else if (txn_done) begin
          state_nxt = WD_IDLE;
        end else if (!eff_dis) begin
          state_nxt = WD_RUN;
        end
      end
      default: state_nxt = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WD_IDLE;
      abort_pulse <= 1'b0;
    end else begin
      state       <= state_nxt;
      abort_pulse <= fire;
    end
  end

  wdt_status u_status (
    .clk  (clk),
    .rst  (rst),
    .set  (fire),
    .clr  (flag_clr),
    .flag (timeout_flag)
  );

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int TMO_W = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           txn_done,
  input logic           cfg_we,
  input logic [TMO_W:0] cfg_wdata,
  input logic [TMO_W:0] cfg_q,
  input logic           flag_clr,
  input logic           abort_pulse,
  input logic           timeout_flag
);

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we) |-> cfg_q == $past(cfg_wdata));

  // R5
  done_blocks_abort_chk: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> !$past(txn_done));

  // R6
  abort_single_chk: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |=> !abort_pulse);

  // R6
  abort_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> timeout_flag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_clr) && !abort_pulse) |-> !timeout_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!abort_pulse && !$past(flag_clr)) |-> $stable(timeout_flag));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> !$past(cfg_q[0]));

endmodule

bind cc_txn_watchdog wdt_chk #(.TMO_W(TMO_W)) u_wdt_chk (
  .clk          (clk),
  .rst          (rst),
  .txn_done     (txn_done),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_q        (cfg_q),
  .flag_clr     (flag_clr),
  .abort_pulse  (abort_pulse),
  .timeout_flag (timeout_flag)
);

// File: tb/tb_cc_txn_watchdog.sv
module tb_cc_txn_watchdog;

  localparam int TMO_W = 7;
  localparam int TICK  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn_start = 1'b0;
  logic txn_done  = 1'b0;
  logic cfg_we    = 1'b0;
  logic [TMO_W:0] cfg_wdata = '0;
  logic [TMO_W:0] cfg_q;
  logic flag_clr = 1'b0;
  logic abort_pulse;
  logic timeout_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cc_txn_watchdog #(.TMO_W(TMO_W), .TICK_CYCLES(TICK)) dut (
    .clk          (clk),
    .rst          (rst),
    .txn_start    (txn_start),
    .txn_done     (txn_done),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_q        (cfg_q),
    .flag_clr     (flag_clr),
    .abort_pulse  (abort_pulse),
    .timeout_flag (timeout_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Each task drives for one edge and returns at the following negedge.
  task automatic write_cfg(input logic [TMO_W:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic start_txn();
    @(negedge clk); txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // Edges after the drive edge until the first abort; -1 if none seen.
  task automatic watch(input int maxc, output int n);
    n = -1;
    for (int k = 1; k <= maxc; k++) begin
      @(negedge clk);
      if (abort_pulse) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic idle(input int c);
    for (int k = 0; k < c; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timer expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(cfg_q == 8'hFE, "R1 cfg reset", int'(cfg_q), 254);
    chk(abort_pulse == 1'b0, "R1 abort reset", int'(abort_pulse), 0);
    chk(timeout_flag == 1'b0, "R1 flag reset", int'(timeout_flag), 0);

    // R12 idle: no transaction, no abort
    watch(500, n);
    chk(n == -1, "R12 idle abort", n, -1);

    // R3/R4 sweep of every timeout code; R2 readback; R6 width/flag; R7 clear
    for (int l = 0; l < 128; l++) begin
      write_cfg({l[TMO_W-1:0], 1'b0});
      chk(cfg_q == {l[TMO_W-1:0], 1'b0}, "R2 cfg readback", int'(cfg_q), l * 2);
      exp = ((l == 0) ? 127 : l) * TICK;
      start_txn();
      watch(exp + 10, n);
      if (l == 0) chk(n == exp, "R4 zero code delay", n, exp);
      else        chk(n == exp, "R3 expiry delay", n, exp);
      @(negedge clk);
      chk(abort_pulse == 1'b0, "R6 abort width", int'(abort_pulse), 0);
      idle(3);
      chk(timeout_flag == 1'b1, "R6 flag sticky", int'(timeout_flag), 1);
      clear_flag();
      chk(timeout_flag == 1'b0, "R7 flag clear", int'(timeout_flag), 0);
    end

    // R7 clear on the expiry edge: the set wins
    write_cfg({7'd4, 1'b0});
    start_txn();
    watch(4 * TICK - 1, n);
    chk(n == -1, "R7 early abort", n, -1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(abort_pulse == 1'b1, "R7 abort on race edge", int'(abort_pulse), 1);
    chk(timeout_flag == 1'b1, "R7 set beats clear", int'(timeout_flag), 1);
    clear_flag();

    // R5 done on the expiry edge suppresses the abort
    start_txn();
    watch(4 * TICK - 1, n);
    txn_done = 1'b1;
    @(negedge clk);
    txn_done = 1'b0;
    chk(abort_pulse == 1'b0, "R5 done on expiry edge", int'(abort_pulse), 0);
    watch(40, n);
    chk(n == -1, "R5 no late abort", n, -1);
    chk(timeout_flag == 1'b0, "R5 flag unchanged", int'(timeout_flag), 0);

    // R8 disabled watchdog never aborts
    write_cfg({7'd5, 1'b1});
    start_txn();
    watch(300, n);
    chk(n == -1, "R8 disabled abort", n, -1);
    chk(timeout_flag == 1'b0, "R8 flag", int'(timeout_flag), 0);

    // R9 re-enable while open restarts from the write edge
    write_cfg({7'd5, 1'b0});
    watch(40, n);
    chk(n == 5 * TICK, "R9 re-enable delay", n, 5 * TICK);
    clear_flag();

    // R10 timeout change while open restarts with the new value
    write_cfg({7'd10, 1'b0});
    start_txn();
    watch(20, n);
    chk(n == -1, "R10 early abort", n, -1);
    write_cfg({7'd4, 1'b0});
    watch(60, n);
    chk(n == 4 * TICK, "R10 new timeout delay", n, 4 * TICK);
    clear_flag();

    // R11 second start restarts the count
    start_txn();
    watch(8, n);
    chk(n == -1, "R11 early abort", n, -1);
    start_txn();
    watch(40, n);
    chk(n == 4 * TICK, "R11 restart delay", n, 4 * TICK);
    clear_flag();

    // R11 start and done together: start wins
    @(negedge clk); txn_start = 1'b1; txn_done = 1'b1;
    @(negedge clk); txn_start = 1'b0; txn_done = 1'b0;
    watch(40, n);
    chk(n == 4 * TICK, "R11 start beats done", n, 4 * TICK);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule